// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Option

This block buffers 36-bit words from a write port clocked by one free-running clock to a read port clocked by a second one. The two clocks may be unrelated, or they may be the same net. In that case a write and a read can both happen on one edge. A transfer happens on the rising edge of its port clock, and only while that port's enable is high. The write pointer and the read pointer cross into the other domain as gray codes through two-stage synchronisers. As a result, the full and empty decisions are at worst late, and never optimistic.

A static mode input is captured while reset is held, and it selects one of two read behaviours:

- **Standard mode:** every word, including the first one, must be fetched by a read. The read side flag reports empty and the write side flag reports full.
- **Fall-through mode:** the head word moves into the output register without a request. The read side flag then reports that the output holds valid data, and the write side flag reports that a free location exists.

Each side also has an almost flag. Each almost flag compares against an offset that is captured during reset, either from a port value or from one of three fixed presets.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave the read port in the order they were written, 36 bits intact, with the write and read clocks running at unrelated rates.
- R2: In standard mode, a written word does not reach `rd_data` until a read is issued. `rd_data` changes only on the read clock edge that performs a read, and shows the word from the first falling edge after that edge.
- R3: In fall-through mode, the first word written into an empty FIFO appears on `rd_data` with `rd_flag` high and no read issued. Each later word appears only after the current one is consumed by a read.
- R4: In standard mode, `rd_flag` high means the storage is empty and `wr_flag` high means it is full.
- R5: In fall-through mode, `rd_flag` high means `rd_data` holds a valid word, and `wr_flag` high means at least one location is free.
- R6: A write while full is discarded; the words read out afterwards are exactly the ones accepted before full.
- R7: A read while empty (standard mode) or while `rd_flag` is low (fall-through mode) is ignored. `rd_data` keeps its value and the read pointer does not move.
- R8: `rd_almost_empty` is high when the word count on the read side is at or below the empty offset. In fall-through mode, the count includes a valid word in the output register.
- R9: `wr_almost_full` is high when the free storage locations number at or below the full offset.
- R10: Offsets are captured during reset through `ofs_sel`: 0 takes `ae_ofs` and `af_ofs`, 1 sets both to 8, 2 sets both to 16, and 3 sets both to 64.
- R11: Reset empties the FIFO. After reset, `rd_almost_empty` is 1, `wr_almost_full` is 0 and `rd_data` is 0. In standard mode `rd_flag`=1 and `wr_flag`=0; in fall-through mode `rd_flag`=0 and `wr_flag`=1.
- R12: Each pointer crossing a clock boundary changes by at most one bit per cycle of its own clock, and the count of stored words never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| rd_clk | input | 1 | Read port clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, shared by both domains |
| fwft_mode | input | 1 | 1 = fall-through mode, 0 = standard; captured during reset |
| ofs_sel | input | 2 | Offset source select, captured during reset |
| ae_ofs | input | log2(DEPTH) | Almost-empty offset used when ofs_sel = 0 |
| af_ofs | input | log2(DEPTH) | Almost-full offset used when ofs_sel = 0 |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write word |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| wr_almost_full | output | 1 | Almost-full flag, write clock domain |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Registered read word |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| rd_almost_empty | output | 1 | Almost-empty flag, read clock domain |

## Verification
A corrupted read pointer shows up on the first read after it: the word returned is out of order or repeated. A write pointer that moves while full shows up once the FIFO is drained, as a lost or foreign word. A stale output-valid bit in fall-through mode shows up at once as a wrong `rd_flag` or an unchanged `rd_data`. Errors in the flag arithmetic appear at the almost flags a few cycles after the pointers settle across the synchronisers. For that reason, every flag check waits for both synchronisers to drain before it samples.

// File: rtl/xf_pkg.sv
package xf_pkg;
    localparam int XF_DATA_W = 36;

    typedef enum logic {
        XF_STD  = 1'b0,
        XF_FWFT = 1'b1
    } xf_mode_e;

    typedef enum logic [1:0] {
        OFS_PORT = 2'd0,
        OFS_8    = 2'd1,
        OFS_16   = 2'd2,
        OFS_64   = 2'd3
    } xf_ofs_sel_e;

    // Gray to binary conversion on a 16-bit container; callers zero-extend.
    function automatic logic [15:0] gray_to_bin(input logic [15:0] g);
        logic [15:0] b;
        b[15] = g[15];
        for (int i = 14; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic logic [15:0] offset_pick(input xf_ofs_sel_e sel,
                                                input logic [15:0] port_val);
        logic [15:0] v;
        case (sel)
            OFS_8:   v = 16'd8;
            OFS_16:  v = 16'd16;
            OFS_64:  v = 16'd64;
            default: v = port_val;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/xf_gray_sync.sv
module xf_gray_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/xf_wr_ctl.sv
module xf_wr_ctl
    import xf_pkg::*;
#(
    parameter  int DEPTH = 512,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwft_mode,
    input  logic [1:0]    ofs_sel,
    input  logic [AW-1:0] af_ofs,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray_sync,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic          wr_flag,
    output logic          almost_full
);
    typedef struct packed {
        xf_mode_e      mode;
        logic [AW-1:0] ofs;
    } cfg_t;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
        logic          afull;
    } wst_t;

    cfg_t          cfg_d, cfg_q;
    wst_t          st_d, st_q;
    logic [PW-1:0] rsync_bin;
    logic [PW-1:0] used_d;
    logic [PW-1:0] free_d;
    logic          push;

    always_comb begin
        cfg_d.mode = xf_mode_e'(fwft_mode);
        cfg_d.ofs  = AW'(offset_pick(xf_ofs_sel_e'(ofs_sel), 16'(af_ofs)));

        rsync_bin  = PW'(gray_to_bin(16'(rgray_sync)));
        push       = wr_en && !st_q.full;

        st_d.bin   = st_q.bin + PW'(push);
        st_d.gray  = st_d.bin ^ (st_d.bin >> 1);
        used_d     = st_d.bin - rsync_bin;
        free_d     = PW'(DEPTH) - used_d;
        st_d.full  = (used_d == PW'(DEPTH));
        st_d.afull = (free_d <= {1'b0, cfg_q.ofs});
    end

    // Configuration is sampled on every clock while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= cfg_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign we          = push;
    assign waddr       = st_q.bin[AW-1:0];
    assign wgray       = st_q.gray;
    assign wr_flag     = (cfg_q.mode == XF_FWFT) ? !st_q.full : st_q.full;
    assign almost_full = st_q.afull;

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bin - rsync_bin) <= PW'(DEPTH));

    // R12
    wgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1);
endmodule

// File: rtl/xf_rd_ctl.sv
module xf_rd_ctl
    import xf_pkg::*;
#(
    parameter  int DEPTH = 512,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwft_mode,
    input  logic [1:0]    ofs_sel,
    input  logic [AW-1:0] ae_ofs,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray_sync,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic          re,
    output logic          rd_flag,
    output logic          almost_empty
);
    typedef struct packed {
        xf_mode_e      mode;
        logic [AW-1:0] ofs;
    } cfg_t;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          ov;
        logic          empty;
        logic          aempty;
    } rst_t;

    cfg_t          cfg_d, cfg_q;
    rst_t          st_d, st_q;
    logic [PW-1:0] wsync_bin;
    logic [PW-1:0] count_d;
    logic          fetch;

    always_comb begin
        cfg_d.mode = xf_mode_e'(fwft_mode);
        cfg_d.ofs  = AW'(offset_pick(xf_ofs_sel_e'(ofs_sel), 16'(ae_ofs)));

        wsync_bin  = PW'(gray_to_bin(16'(wgray_sync)));

        if (cfg_q.mode == XF_FWFT) begin
            fetch   = !st_q.empty && (!st_q.ov || rd_en);
            st_d.ov = fetch ? 1'b1 : (rd_en ? 1'b0 : st_q.ov);
        end else begin
            fetch   = rd_en && !st_q.empty;
            st_d.ov = 1'b0;
        end

        st_d.bin    = st_q.bin + PW'(fetch);
        st_d.gray   = st_d.bin ^ (st_d.bin >> 1);
        st_d.empty  = (st_d.bin == wsync_bin);
        count_d     = (wsync_bin - st_d.bin) + PW'(st_d.ov);
        st_d.aempty = (count_d <= {1'b0, cfg_q.ofs});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= cfg_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.empty  <= 1'b1;
            st_q.aempty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign re           = fetch;
    assign raddr        = st_q.bin[AW-1:0];
    assign rgray        = st_q.gray;
    assign rd_flag      = (cfg_q.mode == XF_FWFT) ? st_q.ov : st_q.empty;
    assign almost_empty = st_q.aempty;

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wsync_bin - st_q.bin) <= PW'(DEPTH));

    // R3
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == XF_FWFT && $fell(st_q.ov)) |-> $past(rd_en));
endmodule

// File: rtl/xf_dpram.sv
module xf_dpram #(
    parameter  int W     = 36,
    parameter  int DEPTH = 512,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rdata_d, rdata_q;

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb begin
        rdata_d = re ? mem[raddr] : rdata_q;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R2
    rdata_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !$past(re) |-> $stable(rdata_q));
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
    import xf_pkg::*;
#(
    parameter  int DEPTH = 512,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                 wr_clk,
    input  logic                 rd_clk,
    input  logic                 rst_n,
    input  logic                 fwft_mode,
    input  logic [1:0]           ofs_sel,
    input  logic [AW-1:0]        ae_ofs,
    input  logic [AW-1:0]        af_ofs,
    input  logic                 wr_en,
    input  logic [XF_DATA_W-1:0] wr_data,
    output logic                 wr_flag,
    output logic                 wr_almost_full,
    input  logic                 rd_en,
    output logic [XF_DATA_W-1:0] rd_data,
    output logic                 rd_flag,
    output logic                 rd_almost_empty
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;
    logic [AW-1:0] waddr, raddr;
    logic          we, re;

    xf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
        .clk         (wr_clk),
        .rst_n       (rst_n),
        .fwft_mode   (fwft_mode),
        .ofs_sel     (ofs_sel),
        .af_ofs      (af_ofs),
        .wr_en       (wr_en),
        .rgray_sync  (rgray_ws),
        .wgray       (wgray),
        .waddr       (waddr),
        .we          (we),
        .wr_flag     (wr_flag),
        .almost_full (wr_almost_full)
    );

    xf_rd_ctl #(.DEPTH(DEPTH)) u_rd (
        .clk          (rd_clk),
        .rst_n        (rst_n),
        .fwft_mode    (fwft_mode),
        .ofs_sel      (ofs_sel),
        .ae_ofs       (ae_ofs),
        .rd_en        (rd_en),
        .wgray_sync   (wgray_rs),
        .rgray        (rgray),
        .raddr        (raddr),
        .re           (re),
        .rd_flag      (rd_flag),
        .almost_empty (rd_almost_empty)
    );

    xf_gray_sync #(.W(PW)) u_w2r (
        .clk  (rd_clk),
        .rst_n(rst_n),
        .din  (wgray),
        .dout (wgray_rs)
    );

    xf_gray_sync #(.W(PW)) u_r2w (
        .clk  (wr_clk),
        .rst_n(rst_n),
        .din  (rgray),
        .dout (rgray_ws)
    );

    xf_dpram #(.W(XF_DATA_W), .DEPTH(DEPTH)) u_mem (
        .wclk (wr_clk),
        .we   (we),
        .waddr(waddr),
        .wdata(wr_data),
        .rclk (rd_clk),
        .rst_n(rst_n),
        .re   (re),
        .raddr(raddr),
        .rdata(rd_data)
    );
endmodule

// File: tb/tb_xclk_fifo.sv
module tb_xclk_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = CLK_PERIOD + 4;
    localparam int DEPTH      = 256;
    localparam int AW         = 8;
    localparam int NV         = 9;
    // mode, ofs_sel, ae_ofs, af_ofs, words written, words read
    localparam int VEC [NV][6] = '{
        '{0, 0, 4, 4,  10,  3},
        '{0, 0, 4, 4,   5,  1},
        '{1, 0, 4, 4,   1,  0},
        '{1, 0, 2, 3,   5,  2},
        '{0, 1, 0, 0,  20, 12},
        '{0, 2, 0, 0, 250,  0},
        '{1, 3, 0, 0, 200, 10},
        '{0, 3, 0, 0, 192,  0},
        '{1, 0, 0, 0,   0,  0}
    };

    logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic          fwft_mode = 1'b0;
    logic [1:0]    ofs_sel = 2'd0;
    logic [AW-1:0] ae_ofs = '0, af_ofs = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [35:0]   wr_data = '0;
    logic [35:0]   rd_data;
    logic          wr_flag, wr_almost_full, rd_flag, rd_almost_empty;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) wclk = ~wclk;
    always #(RD_PERIOD/2)  rclk = ~rclk;

    xclk_fifo #(.DEPTH(DEPTH)) dut (
        .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n),
        .fwft_mode(fwft_mode), .ofs_sel(ofs_sel), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
        .wr_en(wr_en), .wr_data(wr_data), .wr_flag(wr_flag), .wr_almost_full(wr_almost_full),
        .rd_en(rd_en), .rd_data(rd_data), .rd_flag(rd_flag), .rd_almost_empty(rd_almost_empty)
    );

    task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] word_of(int v, int i);
        return {4'(v + 1), 8'h5A, 24'(i)};
    endfunction

    function automatic int eff_ofs(int sel, int p);
        case (sel)
            1: return 8;
            2: return 16;
            3: return 64;
            default: return p;
        endcase
    endfunction

    task automatic do_reset(bit m, int sel, int aeo, int afo);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        fwft_mode = m; ofs_sel = 2'(sel); ae_ofs = AW'(aeo); af_ofs = AW'(afo);
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        rst_n = 1'b1;
        repeat (2) @(negedge wclk);
    endtask

    task automatic wr_words(int v, int start, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wr_en = 1'b1;
            wr_data = word_of(v, start + i);
        end
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (6) @(negedge wclk);
    endtask

    task automatic rd_word(string req, logic [35:0] exp);
        if (fwft_mode) begin
            @(negedge rclk);
            for (int k = 0; k < 20 && rd_flag !== 1'b1; k++) @(negedge rclk);
            chk(req, rd_data, exp);
            rd_en = 1'b1;
            @(negedge rclk);
            rd_en = 1'b0;
        end else begin
            @(negedge rclk);
            rd_en = 1'b1;
            @(negedge rclk);
            rd_en = 1'b0;
            chk(req, rd_data, exp);
        end
    endtask

    task automatic chk_flags(string tg, bit m, int total, int aeo, int afo);
        int ov, memcnt, free_s;
        ov     = (m && total > 0) ? 1 : 0;
        memcnt = total - ov;
        free_s = DEPTH - memcnt;
        @(negedge rclk);
        if (m) chk({tg, " R5 rd_flag ready"}, 36'(rd_flag), 36'(total > 0));
        else   chk({tg, " R4 rd_flag empty"}, 36'(rd_flag), 36'(total == 0));
        chk({tg, " R8 almost empty"}, 36'(rd_almost_empty), 36'(total <= aeo));
        @(negedge wclk);
        if (m) chk({tg, " R5 wr_flag input ready"}, 36'(wr_flag), 36'(free_s != 0));
        else   chk({tg, " R4 wr_flag full"}, 36'(wr_flag), 36'(free_s == 0));
        chk({tg, " R9 almost full"}, 36'(wr_almost_full), 36'(free_s <= afo));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (R1): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [35:0] held;

        // Vector table, one reset per entry
        for (int v = 0; v < NV; v++) begin
            int aeo, afo;
            aeo = eff_ofs(VEC[v][1], VEC[v][2]);
            afo = eff_ofs(VEC[v][1], VEC[v][3]);
            do_reset(VEC[v][0] != 0, VEC[v][1], VEC[v][2], VEC[v][3]);
            wr_words(v, 0, VEC[v][4]);
            settle();
            for (int i = 0; i < VEC[v][5]; i++) rd_word("R1 order", word_of(v, i));
            settle();
            chk_flags((VEC[v][1] != 0) ? "R10 preset" : "vector", VEC[v][0] != 0,
                      VEC[v][4] - VEC[v][5], aeo, afo);
        end

        // R11: reset state, standard mode
        do_reset(1'b0, 0, 4, 4);
        @(negedge rclk);
        chk("R11 std rd_flag", 36'(rd_flag), 36'd1);
        chk("R11 rd_almost_empty", 36'(rd_almost_empty), 36'd1);
        chk("R11 rd_data", rd_data, 36'd0);
        @(negedge wclk);
        chk("R11 std wr_flag", 36'(wr_flag), 36'd0);
        chk("R11 wr_almost_full", 36'(wr_almost_full), 36'd0);

        // R2: word waits for a read in standard mode
        wr_words(30, 0, 1);
        settle();
        @(negedge rclk);
        chk("R2 no read, rd_data unchanged", rd_data, 36'd0);
        chk("R4 not empty", 36'(rd_flag), 36'd0);
        rd_word("R2 read delivers word", word_of(30, 0));

        // R11: reset state, fall-through mode
        do_reset(1'b1, 0, 4, 4);
        @(negedge rclk);
        chk("R11 fwft rd_flag", 36'(rd_flag), 36'd0);
        @(negedge wclk);
        chk("R11 fwft wr_flag", 36'(wr_flag), 36'd1);

        // R3: first word falls through, second waits
        wr_words(31, 0, 1);
        settle();
        @(negedge rclk);
        chk("R3 head shown without read", rd_data, word_of(31, 0));
        chk("R3 ready", 36'(rd_flag), 36'd1);
        wr_words(31, 1, 1);
        settle();
        @(negedge rclk);
        chk("R3 second word waits", rd_data, word_of(31, 0));
        rd_word("R3 pop first", word_of(31, 0));
        rd_word("R3 pop second", word_of(31, 1));
        settle();
        @(negedge rclk);
        chk("R5 not ready after drain", 36'(rd_flag), 36'd0);

        // R6: writes beyond full are dropped
        do_reset(1'b0, 0, 4, 4);
        wr_words(20, 0, DEPTH + 3);
        settle();
        @(negedge wclk);
        chk("R6 full flag", 36'(wr_flag), 36'd1);
        chk("R9 almost full at full", 36'(wr_almost_full), 36'd1);
        for (int i = 0; i < DEPTH; i++) rd_word("R6 stored words", word_of(20, i));
        settle();
        @(negedge rclk);
        chk("R6 empty after DEPTH reads", 36'(rd_flag), 36'd1);

        // R7: read while empty, standard mode
        held = rd_data;
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
        chk("R7 rd_data kept on empty read", rd_data, held);
        chk("R7 still empty", 36'(rd_flag), 36'd1);
        wr_words(21, 0, 1);
        settle();
        rd_word("R7 pointer unmoved", word_of(21, 0));

        // R7: read while not ready, fall-through mode
        do_reset(1'b1, 0, 4, 4);
        @(negedge rclk);
        rd_en = 1'b1;
        repeat (3) @(negedge rclk);
        rd_en = 1'b0;
        chk("R7 fwft not ready", 36'(rd_flag), 36'd0);
        wr_words(22, 0, 1);
        settle();
        @(negedge rclk);
        chk("R7 fwft word after ignored reads", rd_data, word_of(22, 0));
        chk("R8 count 1 at offset 4", 36'(rd_almost_empty), 36'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule